// File: doc/BRIEF.md
# Dual GPIO with Edge Detect and Alert

This block provides two independent general-purpose digital pins, each with its own 8-bit control register on a simple register bus. A pin can drive a value held in its register, or it can act as an input. An input passes through a synchronizer. Its level can be read back through the register. It can also be watched for a chosen edge, and that edge sets a sticky flag.

Each pin also has an alert mode. In this mode the pin is forced to drive and follows a per-pin fault input through a programmable polarity. The alert takes priority over the register's drive value. Firmware writes a register to configure a pin. It reads the same register to see the pin level and the flag, and writes a 1 to the flag to clear it.

Each control register uses this layout: bit 0 selects output (1) or input (0). Bit 1 is the drive value. Bit 2 selects edge sensing (1) or level sensing (0). Bit 3 picks the falling edge (1) or the rising edge (0). Bit 4 enables alert mode, and bit 5 is the alert polarity: 1 drives high on a fault, 0 drives low on a fault. Bit 6 is the sticky edge flag, cleared by writing 1. Bit 7 is the synchronized pin level and is read-only.

Top module: `gpio_pair_ctrl`

## Requirements
- R1: After synchronous reset, both control registers read 0x00, both `pin_oe` bits are 0, both `pin_out` bits are 0 and `bus_rdata` is 0x00.
- R2: Channel 0's register is at address 0x40 and channel 1's register is at 0x41. A read of any other address returns 0x00, and a write to any other address changes neither register.
- R3: With bit 0 = 1 and bit 4 = 0, the pin drives (`pin_oe` = 1) and `pin_out` equals bit 1 from the clock edge that takes the write.
- R4: With bit 0 = 0 and bit 4 = 0, `pin_oe` is 0 and `pin_out` is 0. Bit 7 reads back the pin level after a two-stage synchronizer.
- R5: With bit 2 = 1 on an input pin, bit 3 = 0 sets bit 6 on a synchronized 0-to-1 transition only. Bit 3 = 1 sets it on a 1-to-0 transition only.
- R6: With bit 2 = 0, no pin transition sets bit 6.
- R7: Bit 6 holds until a write puts a 1 in bit 6. Writing 0 to bit 6 leaves it unchanged, and the value written to bit 7 is ignored.
- R8: If a selected edge and a clearing write reach bit 6 in the same cycle, bit 6 ends up set.
- R9: With bit 4 = 1, `pin_oe` is 1. In the same cycle, `pin_out` equals bit 5 while the pin's fault input is 1, and the inverse of bit 5 while it is 0, regardless of bit 1.
- R10: Writes, pin activity and faults on one channel have no effect on the other channel's register or pin outputs.
- R11: No edge sets bit 6 while the pin is an output (bit 0 = 1) or in alert mode (bit 4 = 1).
- R12: `bus_rdata` is loaded only on a clock edge where `bus_rd` is 1, one cycle after the address is presented, and it holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 2 | Pad input levels, one per channel |
| fault_in | input | 2 | Fault conditions, one per channel |
| pin_out | output | 2 | Pad output values |
| pin_oe | output | 2 | Pad output enables |

## Verification
Some properties are checked on every cycle: the pin drive rules for output, input and alert modes, including the fault-to-pin path in the same cycle. The flag may only rise when edge sensing was armed, and it may only fall after a clearing write. The read data must hold without a read strobe, and the outputs must be quiet after reset. Other behaviours need the bench's scenarios: the synchronizer latency, which edge polarity sets the flag, and the collision between a clearing write and a new edge in the same cycle. The same applies to address decoding of unmapped locations and to isolation between the two channels.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
  localparam int CTL_W = 8;

  // Read view of one control register, MSB first.
  typedef struct packed {
    logic pin_lvl;    // 7: synchronized pad level, read-only
    logic edge_seen;  // 6: sticky edge flag, write 1 to clear
    logic alert_hi;   // 5: alert polarity
    logic alert_on;   // 4: alert mode enable
    logic edge_fall;  // 3: 1 = falling edge, 0 = rising edge
    logic edge_mode;  // 2: 1 = edge sensing, 0 = level sensing
    logic drive_val;  // 1: output value
    logic is_out;     // 0: 1 = output, 0 = input
  } gpio_ctl_t;

  // Writable configuration bits only.
  typedef struct packed {
    logic alert_hi;
    logic alert_on;
    logic edge_fall;
    logic edge_mode;
    logic drive_val;
    logic is_out;
  } gpio_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_flag.sv
module gpio_edge_flag (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic arm,
  input  logic fall_sel,
  input  logic clr,
  output logic flag
);
  logic lvl_d;
  logic hit;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl;
  end

  assign hit = arm & (fall_sel ? (lvl_d & ~lvl) : (lvl & ~lvl_d));

  // A new edge wins over a clearing write in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/gpio_channel.sv
module gpio_channel
  import gpio_pair_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  gpio_cfg_t wr_cfg,
  input  logic      wr_clr,
  input  logic      pad_in,
  input  logic      fault,
  output logic      pad_out,
  output logic      pad_oe,
  output gpio_ctl_t view
);
  gpio_cfg_t cfg;
  logic      lvl_sync;
  logic      flag;
  logic      arm;

  always_ff @(posedge clk) begin
    if (rst)        cfg <= '0;
    else if (wr_en) cfg <= wr_cfg;
  end

  gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (lvl_sync)
  );

  assign arm = cfg.edge_mode & ~cfg.is_out & ~cfg.alert_on;

  gpio_edge_flag u_edge (
    .clk      (clk),
    .rst      (rst),
    .lvl      (lvl_sync),
    .arm      (arm),
    .fall_sel (cfg.edge_fall),
    .clr      (wr_en & wr_clr),
    .flag     (flag)
  );

  always_comb begin
    if (cfg.alert_on) begin
      pad_oe  = 1'b1;
      pad_out = fault ? cfg.alert_hi : ~cfg.alert_hi;
    end else begin
      pad_oe  = cfg.is_out;
      pad_out = cfg.is_out & cfg.drive_val;
    end
  end

  always_comb begin
    view           = '0;
    view.pin_lvl   = lvl_sync;
    view.edge_seen = flag;
    view.alert_hi  = cfg.alert_hi;
    view.alert_on  = cfg.alert_on;
    view.edge_fall = cfg.edge_fall;
    view.edge_mode = cfg.edge_mode;
    view.drive_val = cfg.drive_val;
    view.is_out    = cfg.is_out;
  end
endmodule

// File: rtl/gpio_pair_ctrl.sv
module gpio_pair_ctrl
  import gpio_pair_pkg::*;
#(
  parameter int                NUM_CH      = 2,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 'h40,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTL_W-1:0]  bus_wdata,
  output logic [CTL_W-1:0]  bus_rdata,
  input  logic [NUM_CH-1:0] pin_in,
  input  logic [NUM_CH-1:0] fault_in,
  output logic [NUM_CH-1:0] pin_out,
  output logic [NUM_CH-1:0] pin_oe
);
  gpio_ctl_t [NUM_CH-1:0] ctl_flat;
  logic      [NUM_CH-1:0] sel;
  gpio_cfg_t              wr_cfg;
  logic                   wr_clr;
  logic [CTL_W-1:0]       rd_mux;
  logic                   unused_wdata_msb;

  assign wr_cfg           = gpio_cfg_t'(bus_wdata[5:0]);
  assign wr_clr           = bus_wdata[6];
  assign unused_wdata_msb = bus_wdata[7];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign sel[i] = (bus_addr == BASE_ADDR + ADDR_W'(i));

    gpio_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bus_wr & sel[i]),
      .wr_cfg  (wr_cfg),
      .wr_clr  (wr_clr),
      .pad_in  (pin_in[i]),
      .fault   (fault_in[i]),
      .pad_out (pin_out[i]),
      .pad_oe  (pin_oe[i]),
      .view    (ctl_flat[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (sel[k]) rd_mux = ctl_flat[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_pair_chk.sv
module gpio_pair_chk #(
  parameter int                NUM_CH    = 2,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_wr,
  input logic                   bus_rd,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   wr_clr,
  input logic [7:0]             bus_rdata,
  input logic [NUM_CH-1:0]      fault_in,
  input logic [NUM_CH-1:0]      pin_out,
  input logic [NUM_CH-1:0]      pin_oe,
  input logic [NUM_CH-1:0][7:0] ctl_flat
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0 && bus_rdata == '0));

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    wire unused_c = ctl_flat[i][3] ^ ctl_flat[i][7];

    p_output_drive_r3: assert property (@(posedge clk) disable iff (rst)
      (ctl_flat[i][0] && !ctl_flat[i][4]) |-> (pin_oe[i] && pin_out[i] == ctl_flat[i][1]));

    p_input_release_r4: assert property (@(posedge clk) disable iff (rst)
      (!ctl_flat[i][0] && !ctl_flat[i][4]) |-> (!pin_oe[i] && !pin_out[i]));

    p_alert_follow_r9: assert property (@(posedge clk) disable iff (rst)
      ctl_flat[i][4] |-> (pin_oe[i] && pin_out[i] == (fault_in[i] ~^ ctl_flat[i][5])));

    p_flag_armed_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(ctl_flat[i][6]) |-> $past(ctl_flat[i][2] && !ctl_flat[i][0] && !ctl_flat[i][4]));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (ctl_flat[i][6] && !(bus_wr && wr_clr && bus_addr == BASE_ADDR + ADDR_W'(i)))
        |=> ctl_flat[i][6]);
  end
endmodule

bind gpio_pair_ctrl gpio_pair_chk #(
  .NUM_CH    (NUM_CH),
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .wr_clr    (bus_wdata[6]),
  .bus_rdata (bus_rdata),
  .fault_in  (fault_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .ctl_flat  (ctl_flat)
);

// File: tb/gpio_pair_ctrl_bench.sv
module gpio_pair_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] pin_in = '0;
  logic [1:0] fault_in = '0;
  logic [1:0] pin_out;
  logic [1:0] pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic rd_d = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      req;
  } sb_item_t;
  sb_item_t exp_q[$];

  always #2.5 clk = ~clk;

  gpio_pair_ctrl u_gpio_pair_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .fault_in  (fault_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string req);
    exp_q.push_back('{e, req});
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  // Scoreboard monitor: pops one expected item per completed read.
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard-empty", 8'h01, 8'h00);
      end else begin
        sb_item_t it;
        it = exp_q.pop_front();
        chk(it.req, bus_rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle(4);
    rst = 1'b0;
    // R1 reset state
    chk("R1 oe", {6'd0, pin_oe}, 8'h00);
    chk("R1 out", {6'd0, pin_out}, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
    rd(8'h40, 8'h00, "R1 ch0");
    rd(8'h41, 8'h00, "R1 ch1");

    // R3 output mode on ch0
    wr(8'h40, 8'h03);
    chk("R3 oe", {7'd0, pin_oe[0]}, 8'h01);
    chk("R3 out high", {7'd0, pin_out[0]}, 8'h01);
    rd(8'h40, 8'h03, "R3 readback");
    wr(8'h40, 8'h01);
    chk("R3 out low", {7'd0, pin_out[0]}, 8'h00);
    chk("R10 ch1 undisturbed oe", {7'd0, pin_oe[1]}, 8'h00);
    rd(8'h41, 8'h00, "R10 ch1 reg");

    // R2 address map
    wr(8'h42, 8'hFF);
    rd(8'h42, 8'h00, "R2 unmapped 42");
    rd(8'h3F, 8'h00, "R2 unmapped 3F");
    rd(8'h40, 8'h01, "R2 ch0 kept");
    rd(8'h41, 8'h00, "R2 ch1 kept");

    // R4 / R6 level mode on ch1
    pin_in[1] = 1'b1; idle(4);
    rd(8'h41, 8'h80, "R4 level high");
    chk("R4 oe", {7'd0, pin_oe[1]}, 8'h00);
    pin_in[1] = 1'b0; idle(4);
    rd(8'h41, 8'h00, "R6 no flag in level mode");

    // R5 rising edge, R7 sticky and clear
    wr(8'h41, 8'h04);
    pin_in[1] = 1'b1; idle(4);
    rd(8'h41, 8'hC4, "R5 rising sets flag");
    pin_in[1] = 1'b0; idle(4);
    rd(8'h41, 8'h44, "R5 flag kept after fall");
    wr(8'h41, 8'h04);
    rd(8'h41, 8'h44, "R7 write 0 keeps flag");
    wr(8'h41, 8'h44);
    rd(8'h41, 8'h04, "R7 write 1 clears flag");
    wr(8'h41, 8'h84);
    rd(8'h41, 8'h04, "R7 bit7 write ignored");

    // R5 falling edge select
    wr(8'h41, 8'h0C);
    pin_in[1] = 1'b1; idle(4);
    rd(8'h41, 8'h8C, "R5 rise ignored in fall mode");
    pin_in[1] = 1'b0; idle(4);
    rd(8'h41, 8'h4C, "R5 falling sets flag");
    wr(8'h41, 8'h4C);
    rd(8'h41, 8'h0C, "R7 clear");

    // R8 edge vs clear collision
    pin_in[1] = 1'b1; idle(4);
    pin_in[1] = 1'b0; idle(4);
    wr(8'h41, 8'h04);
    rd(8'h41, 8'h44, "R8 setup flag set");
    pin_in[1] = 1'b1;
    idle(2);
    wr(8'h41, 8'h44);
    idle(2);
    rd(8'h41, 8'hC4, "R8 edge wins over clear");
    wr(8'h41, 8'h44);
    rd(8'h41, 8'h84, "R7 clear without edge");

    // R11 output mode blocks edge detection
    wr(8'h41, 8'h05);
    pin_in[1] = 1'b0; idle(4);
    pin_in[1] = 1'b1; idle(4);
    rd(8'h41, 8'h85, "R11 no flag while output");
    chk("R3 ch1 drives low", {6'd0, pin_oe[1], pin_out[1]}, 8'h02);

    // R9 alert mode on ch0
    wr(8'h40, 8'h11);
    fault_in[0] = 1'b0; #1;
    chk("R9 idle active-low alert", {6'd0, pin_oe[0], pin_out[0]}, 8'h03);
    fault_in[0] = 1'b1; #1;
    chk("R9 fault drives low", {6'd0, pin_oe[0], pin_out[0]}, 8'h02);
    chk("R10 ch1 unaffected by fault", {6'd0, pin_oe[1], pin_out[1]}, 8'h02);
    @(negedge clk);
    wr(8'h40, 8'h30);
    chk("R9 fault drives high", {6'd0, pin_oe[0], pin_out[0]}, 8'h03);
    fault_in[0] = 1'b0; #1;
    chk("R9 no fault low", {6'd0, pin_oe[0], pin_out[0]}, 8'h02);
    @(negedge clk);
    wr(8'h40, 8'h32);
    chk("R9 overrides drive bit", {7'd0, pin_out[0]}, 8'h00);
    fault_in[0] = 1'b1; #1;
    chk("R9 fault with drive bit", {7'd0, pin_out[0]}, 8'h01);
    @(negedge clk);

    // R11 alert mode blocks edge detection
    wr(8'h40, 8'h34);
    pin_in[0] = 1'b1; idle(4);
    rd(8'h40, 8'hB4, "R11 no flag in alert mode");

    // R12 read data holds without strobe
    wr(8'h40, 8'h00);
    idle(2);
    chk("R12 rdata held", bus_rdata, 8'hB4);
    rd(8'h40, 8'h80, "R12 new read updates");

    idle(2);
    chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule